// File: doc/BRIEF.md
# VMID and ASID Tagged Combined TLB

This block is a small, fully associative translation cache for a core with a hypervisor mode. It holds two kinds of entries side by side. Guest entries map a guest virtual page straight to a host physical page, already combining both translation stages. Host entries map a host virtual page to a physical page. Each entry carries a guest/host flag, a virtual machine identifier (VMID), an address space identifier (ASID), a global flag, the virtual page number and the physical page number.

The walker fills entries through a refill port. Replacement is round-robin, except that a refill carrying a tag already present rewrites that entry in place. The lookup port takes a tag and returns hit and physical page one cycle later.

Three kinds of fence clear entries. These are a supervisor fence issued in host or guest mode, a guest-virtual fence, and a guest-physical fence. Each fence can be limited by ASID, by page, or by VMID. The scope of each fence depends on the mode it was issued in and on the current VMID. Guest entries keep no guest physical address, so a guest-physical fence can only clear by VMID.

Top module: `tlb_vmid_asid`

## Requirements
- R1: After reset every entry is invalid, so `lk_hit` is 0 and any lookup misses.
- R2: A lookup registered at one clock edge drives `lk_hit` and `lk_ppn` from that edge onward. The lookup hits an entry when all of these hold:
  - the entry is valid;
  - its guest flag equals `lk_virt`;
  - its VPN equals `lk_vpn`;
  - its ASID equals `lk_asid`, or the entry is global;
  - for a guest entry, its VMID equals `lk_vmid`.
  When several entries hit, the lowest-indexed one supplies `lk_ppn`.
- R3: A lookup in the same cycle as `fn_valid` returns a miss.
- R4: Each accepted refill whose exact tag is not present goes into the next slot in round-robin order, 0 up to ENTRIES-1 and then wrapping to 0. The exact tag is the guest flag, VMID, ASID, VPN and global flag. The pointer starts at slot 0 after reset. A refill whose exact tag matches a valid entry rewrites that entry and leaves the pointer where it was.
- R5: A refill in the same cycle as `fn_valid` is dropped.
- R6: A supervisor fence (`fn_kind`=0) with `fn_virt`=0 clears only host entries. If `fn_use_asid` is set, it is limited to entries whose ASID equals `fn_asid`. If `fn_use_vpn` is set, it is limited to entries whose VPN equals `fn_vpn`.
- R7: A supervisor fence with `fn_virt`=1, and a guest-virtual fence (`fn_kind`=1), clear only guest entries whose VMID equals `fn_cur_vmid`. Both apply the same ASID and VPN limits as R6.
- R8: A guest-physical fence (`fn_kind`=2) clears guest entries whose VMID equals `fn_vmid` when `fn_use_vmid` is set, and all guest entries otherwise. It ignores `fn_use_vpn`, `fn_vpn` and the ASID inputs. It never clears host entries.
- R9: Global entries survive any fence limited by ASID. They are cleared by fences limited by page or VMID, and by unlimited fences.
- R10: `fn_kind`=3 is reserved and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_virt | input | 1 | Lookup is a guest access |
| lk_vmid | input | VMID_W | Lookup VMID |
| lk_asid | input | ASID_W | Lookup ASID |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_hit | output | 1 | Registered hit |
| lk_ppn | output | PPN_W | Registered physical page number |
| rf_valid | input | 1 | Refill request |
| rf_virt | input | 1 | Refill entry is a guest entry |
| rf_vmid | input | VMID_W | Refill VMID |
| rf_asid | input | ASID_W | Refill ASID |
| rf_vpn | input | VPN_W | Refill virtual page number |
| rf_glob | input | 1 | Refill entry is global |
| rf_ppn | input | PPN_W | Refill physical page number |
| fn_valid | input | 1 | Fence request |
| fn_kind | input | 2 | 0 supervisor, 1 guest-virtual, 2 guest-physical, 3 reserved |
| fn_virt | input | 1 | Mode in which the supervisor fence was issued |
| fn_cur_vmid | input | VMID_W | Current VMID |
| fn_use_asid | input | 1 | Limit the fence by ASID |
| fn_asid | input | ASID_W | ASID operand |
| fn_use_vpn | input | 1 | Limit the fence by page |
| fn_vpn | input | VPN_W | Page operand |
| fn_use_vmid | input | 1 | Limit the guest-physical fence by VMID |
| fn_vmid | input | VMID_W | VMID operand |

## Verification
Lookups run against a mix of host, guest and global entries that share a VPN and differ only in flag, VMID or ASID. This shows that each tag field takes part in the compare. Every fence kind is applied to a population spread across both modes and several VMIDs and ASIDs, so a fence that reaches too far or not far enough shows up as a wrong hit on a survivor. The guest-physical fence is also given a non-matching page operand, to show the address is ignored. A refill that repeats a resident tag is followed by a new refill. Which entry that new refill evicts shows whether the round-robin pointer moved.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    FK_SUPV = 2'd0,
    FK_GVIRT = 2'd1,
    FK_GPHYS = 2'd2,
    FK_RSVD = 2'd3
  } fence_kind_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int VMID_W = 7,
  parameter int ASID_W = 9,
  parameter int VPN_W  = 27
) (
  input  logic              e_valid,
  input  logic              e_virt,
  input  logic              e_glob,
  input  logic [VMID_W-1:0] e_vmid,
  input  logic [ASID_W-1:0] e_asid,
  input  logic [VPN_W-1:0]  e_vpn,
  input  logic              q_virt,
  input  logic [VMID_W-1:0] q_vmid,
  input  logic [ASID_W-1:0] q_asid,
  input  logic [VPN_W-1:0]  q_vpn,
  output logic              hit
);
  logic vmid_ok, asid_ok;
  always_comb begin
    vmid_ok = !e_virt || (e_vmid == q_vmid);
    asid_ok = e_glob || (e_asid == q_asid);
    hit = e_valid && (e_virt == q_virt) && vmid_ok && asid_ok && (e_vpn == q_vpn);
  end
endmodule

// File: rtl/tlb_fence_scope.sv
module tlb_fence_scope
  import tlb_pkg::*;
#(
  parameter int VMID_W = 7,
  parameter int ASID_W = 9,
  parameter int VPN_W  = 27
) (
  input  logic              e_valid,
  input  logic              e_virt,
  input  logic              e_glob,
  input  logic [VMID_W-1:0] e_vmid,
  input  logic [ASID_W-1:0] e_asid,
  input  logic [VPN_W-1:0]  e_vpn,
  input  logic              fn_valid,
  input  fence_kind_e       fn_kind,
  input  logic              fn_virt,
  input  logic [VMID_W-1:0] fn_cur_vmid,
  input  logic              fn_use_asid,
  input  logic [ASID_W-1:0] fn_asid,
  input  logic              fn_use_vpn,
  input  logic [VPN_W-1:0]  fn_vpn,
  input  logic              fn_use_vmid,
  input  logic [VMID_W-1:0] fn_vmid,
  output logic              kill
);
  logic asid_ok, vpn_ok, cur_guest, sel;
  always_comb begin
    // ASID-limited fences spare global entries
    asid_ok   = !fn_use_asid || (!e_glob && (e_asid == fn_asid));
    vpn_ok    = !fn_use_vpn || (e_vpn == fn_vpn);
    cur_guest = e_virt && (e_vmid == fn_cur_vmid);
    unique case (fn_kind)
      FK_SUPV:  sel = (fn_virt ? cur_guest : !e_virt) && asid_ok && vpn_ok;
      FK_GVIRT: sel = cur_guest && asid_ok && vpn_ok;
      FK_GPHYS: sel = e_virt && (!fn_use_vmid || (e_vmid == fn_vmid));
      default:  sel = 1'b0;
    endcase
    kill = fn_valid && e_valid && sel;
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);
  generate
    if ((ENTRIES & (ENTRIES - 1)) == 0) begin : g_pow2
      always_ff @(posedge clk) begin
        if (rst) ptr <= '0;
        else if (adv) ptr <= ptr + 1'b1;
      end
    end else begin : g_wrap
      always_ff @(posedge clk) begin
        if (rst) ptr <= '0;
        else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/tlb_vmid_asid.sv
module tlb_vmid_asid
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VMID_W  = 7,
  parameter int ASID_W  = 9,
  parameter int VPN_W   = 27,
  parameter int PPN_W   = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic              lk_virt,
  input  logic [VMID_W-1:0] lk_vmid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  input  logic              rf_valid,
  input  logic              rf_virt,
  input  logic [VMID_W-1:0] rf_vmid,
  input  logic [ASID_W-1:0] rf_asid,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic              rf_glob,
  input  logic [PPN_W-1:0]  rf_ppn,
  input  logic              fn_valid,
  input  logic [1:0]        fn_kind,
  input  logic              fn_virt,
  input  logic [VMID_W-1:0] fn_cur_vmid,
  input  logic              fn_use_asid,
  input  logic [ASID_W-1:0] fn_asid,
  input  logic              fn_use_vpn,
  input  logic [VPN_W-1:0]  fn_vpn,
  input  logic              fn_use_vmid,
  input  logic [VMID_W-1:0] fn_vmid
);
  localparam int IDX_W = $clog2(ENTRIES);

  // entry storage
  logic [ENTRIES-1:0] valid_v;
  logic [ENTRIES-1:0] virt_v;
  logic [ENTRIES-1:0] glob_v;
  logic [VMID_W-1:0]  vmid_q [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];

  logic [ENTRIES-1:0] hit_v;
  logic [ENTRIES-1:0] dup_loose_v;
  logic [ENTRIES-1:0] dup_v;
  logic [ENTRIES-1:0] kill_v;
  logic [ENTRIES-1:0] wr_en;
  logic [IDX_W-1:0]   rr_ptr;
  logic [IDX_W-1:0]   dup_idx;
  logic [IDX_W-1:0]   wr_idx;
  logic [PPN_W-1:0]   sel_ppn;
  logic               rf_accept;
  logic               rr_adv;
  fence_kind_e        kind;

  assign kind = fence_kind_e'(fn_kind);

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_ent
      tlb_match #(.VMID_W(VMID_W), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_lk (
        .e_valid(valid_v[g]), .e_virt(virt_v[g]), .e_glob(glob_v[g]),
        .e_vmid(vmid_q[g]), .e_asid(asid_q[g]), .e_vpn(vpn_q[g]),
        .q_virt(lk_virt), .q_vmid(lk_vmid), .q_asid(lk_asid), .q_vpn(lk_vpn),
        .hit(hit_v[g])
      );
      tlb_match #(.VMID_W(VMID_W), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_rf (
        .e_valid(valid_v[g]), .e_virt(virt_v[g]), .e_glob(glob_v[g]),
        .e_vmid(vmid_q[g]), .e_asid(asid_q[g]), .e_vpn(vpn_q[g]),
        .q_virt(rf_virt), .q_vmid(rf_vmid), .q_asid(rf_asid), .q_vpn(rf_vpn),
        .hit(dup_loose_v[g])
      );
      // exact tag: also same ASID and same global flag
      assign dup_v[g] = dup_loose_v[g] && (asid_q[g] == rf_asid) && (glob_v[g] == rf_glob);

      tlb_fence_scope #(.VMID_W(VMID_W), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_fs (
        .e_valid(valid_v[g]), .e_virt(virt_v[g]), .e_glob(glob_v[g]),
        .e_vmid(vmid_q[g]), .e_asid(asid_q[g]), .e_vpn(vpn_q[g]),
        .fn_valid(fn_valid), .fn_kind(kind), .fn_virt(fn_virt),
        .fn_cur_vmid(fn_cur_vmid), .fn_use_asid(fn_use_asid), .fn_asid(fn_asid),
        .fn_use_vpn(fn_use_vpn), .fn_vpn(fn_vpn), .fn_use_vmid(fn_use_vmid),
        .fn_vmid(fn_vmid), .kill(kill_v[g])
      );
    end
  endgenerate

  // lowest index wins for both the output mux and the duplicate slot
  always_comb begin
    sel_ppn = '0;
    dup_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_v[i]) sel_ppn = ppn_q[i];
      if (dup_v[i]) dup_idx = IDX_W'(i);
    end
  end

  always_comb begin
    rf_accept = rf_valid && !fn_valid;
    wr_idx    = (|dup_v) ? dup_idx : rr_ptr;
    rr_adv    = rf_accept && !(|dup_v);
    for (int i = 0; i < ENTRIES; i++) begin
      wr_en[i] = rf_accept && (wr_idx == IDX_W'(i));
    end
  end

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .adv(rr_adv), .ptr(rr_ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_v <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_en[i]) valid_v[i] <= 1'b1;
        else if (kill_v[i]) valid_v[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_en[i]) begin
        virt_v[i] <= rf_virt;
        glob_v[i] <= rf_glob;
        vmid_q[i] <= rf_vmid;
        asid_q[i] <= rf_asid;
        vpn_q[i]  <= rf_vpn;
        ppn_q[i]  <= rf_ppn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit <= 1'b0;
      lk_ppn <= '0;
    end else begin
      lk_hit <= lk_valid && !fn_valid && (|hit_v);
      lk_ppn <= sel_ppn;
    end
  end
endmodule

// File: rtl/tlb_vmid_asid_chk.sv
module tlb_vmid_asid_chk #(
  parameter int ENTRIES = 8,
  parameter int VMID_W  = 7,
  parameter int ASID_W  = 9,
  parameter int VPN_W   = 27
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic              lk_virt,
  input logic [VMID_W-1:0] lk_vmid,
  input logic [ASID_W-1:0] lk_asid,
  input logic [VPN_W-1:0]  lk_vpn,
  input logic              lk_hit,
  input logic              rf_valid,
  input logic              rf_virt,
  input logic [VMID_W-1:0] rf_vmid,
  input logic [ASID_W-1:0] rf_asid,
  input logic [VPN_W-1:0]  rf_vpn,
  input logic              fn_valid,
  input logic [1:0]        fn_kind,
  input logic              fn_virt,
  input logic              fn_use_vmid,
  input logic [ENTRIES-1:0] valid_v,
  input logic [ENTRIES-1:0] virt_v
);
  p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (valid_v == '0 && !lk_hit));

  p_idle_nohit_r2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !lk_hit);

  p_fence_miss_r3: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && fn_valid) |=> !lk_hit);

  p_refill_visible_r4: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !fn_valid && $past(rf_valid && !fn_valid) &&
     lk_virt == $past(rf_virt) && lk_vmid == $past(rf_vmid) &&
     lk_asid == $past(rf_asid) && lk_vpn == $past(rf_vpn)) |=> lk_hit);

  p_refill_dropped_r5: assert property (@(posedge clk) disable iff (rst)
    (fn_valid && rf_valid) |=> ($countones(valid_v) <= $countones($past(valid_v))));

  p_host_fence_spares_guest_r6: assert property (@(posedge clk) disable iff (rst)
    (fn_valid && fn_kind == 2'd0 && !fn_virt) |=>
      ((valid_v & virt_v) == $past(valid_v & virt_v)));

  p_gphys_spares_host_r8: assert property (@(posedge clk) disable iff (rst)
    (fn_valid && fn_kind == 2'd2) |=>
      ((valid_v & ~virt_v) == $past(valid_v & ~virt_v)));

  p_gphys_all_r8: assert property (@(posedge clk) disable iff (rst)
    (fn_valid && fn_kind == 2'd2 && !fn_use_vmid) |=> ((valid_v & virt_v) == '0));

  p_rsvd_noop_r10: assert property (@(posedge clk) disable iff (rst)
    (fn_valid && fn_kind == 2'd3) |=> (valid_v == $past(valid_v)));
endmodule

bind tlb_vmid_asid tlb_vmid_asid_chk #(
  .ENTRIES(ENTRIES), .VMID_W(VMID_W), .ASID_W(ASID_W), .VPN_W(VPN_W)
) u_chk (
  .clk(clk), .rst(rst),
  .lk_valid(lk_valid), .lk_virt(lk_virt), .lk_vmid(lk_vmid),
  .lk_asid(lk_asid), .lk_vpn(lk_vpn), .lk_hit(lk_hit),
  .rf_valid(rf_valid), .rf_virt(rf_virt), .rf_vmid(rf_vmid),
  .rf_asid(rf_asid), .rf_vpn(rf_vpn),
  .fn_valid(fn_valid), .fn_kind(fn_kind), .fn_virt(fn_virt),
  .fn_use_vmid(fn_use_vmid), .valid_v(valid_v), .virt_v(virt_v)
);

// File: tb/tb_tlb_vmid_asid.sv
`timescale 1ns/1ps
module tb_tlb_vmid_asid;
  localparam int ENTRIES = 8;
  localparam int VMID_W  = 7;
  localparam int ASID_W  = 9;
  localparam int VPN_W   = 27;
  localparam int PPN_W   = 28;

  logic clk = 1'b0;
  logic rst;
  logic lk_valid, lk_virt;
  logic [VMID_W-1:0] lk_vmid;
  logic [ASID_W-1:0] lk_asid;
  logic [VPN_W-1:0]  lk_vpn;
  logic lk_hit;
  logic [PPN_W-1:0] lk_ppn;
  logic rf_valid, rf_virt, rf_glob;
  logic [VMID_W-1:0] rf_vmid;
  logic [ASID_W-1:0] rf_asid;
  logic [VPN_W-1:0]  rf_vpn;
  logic [PPN_W-1:0]  rf_ppn;
  logic fn_valid, fn_virt, fn_use_asid, fn_use_vpn, fn_use_vmid;
  logic [1:0] fn_kind;
  logic [VMID_W-1:0] fn_cur_vmid, fn_vmid;
  logic [ASID_W-1:0] fn_asid;
  logic [VPN_W-1:0]  fn_vpn;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  tlb_vmid_asid #(
    .ENTRIES(ENTRIES), .VMID_W(VMID_W), .ASID_W(ASID_W), .VPN_W(VPN_W), .PPN_W(PPN_W)
  ) dut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_virt(lk_virt), .lk_vmid(lk_vmid), .lk_asid(lk_asid),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .rf_valid(rf_valid), .rf_virt(rf_virt), .rf_vmid(rf_vmid), .rf_asid(rf_asid),
    .rf_vpn(rf_vpn), .rf_glob(rf_glob), .rf_ppn(rf_ppn),
    .fn_valid(fn_valid), .fn_kind(fn_kind), .fn_virt(fn_virt), .fn_cur_vmid(fn_cur_vmid),
    .fn_use_asid(fn_use_asid), .fn_asid(fn_asid), .fn_use_vpn(fn_use_vpn),
    .fn_vpn(fn_vpn), .fn_use_vmid(fn_use_vmid), .fn_vmid(fn_vmid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    lk_valid = 0; lk_virt = 0; lk_vmid = '0; lk_asid = '0; lk_vpn = '0;
    rf_valid = 0; rf_virt = 0; rf_vmid = '0; rf_asid = '0; rf_vpn = '0;
    rf_glob = 0; rf_ppn = '0;
    fn_valid = 0; fn_kind = 2'd0; fn_virt = 0; fn_cur_vmid = '0; fn_use_asid = 0;
    fn_asid = '0; fn_use_vpn = 0; fn_vpn = '0; fn_use_vmid = 0; fn_vmid = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic set_refill(input bit virt, input int vmid, input int asid,
                            input int vpn, input int ppn, input bit glob);
    rf_valid = 1; rf_virt = virt; rf_vmid = VMID_W'(vmid); rf_asid = ASID_W'(asid);
    rf_vpn = VPN_W'(vpn); rf_ppn = PPN_W'(ppn); rf_glob = glob;
  endtask

  task automatic set_fence(input int kind, input bit virt, input int cur,
                           input bit ua, input int asid, input bit uv, input int vpn,
                           input bit um, input int vmid);
    fn_valid = 1; fn_kind = 2'(kind); fn_virt = virt; fn_cur_vmid = VMID_W'(cur);
    fn_use_asid = ua; fn_asid = ASID_W'(asid); fn_use_vpn = uv; fn_vpn = VPN_W'(vpn);
    fn_use_vmid = um; fn_vmid = VMID_W'(vmid);
  endtask

  task automatic set_look(input bit virt, input int vmid, input int asid, input int vpn);
    lk_valid = 1; lk_virt = virt; lk_vmid = VMID_W'(vmid);
    lk_asid = ASID_W'(asid); lk_vpn = VPN_W'(vpn);
  endtask

  task automatic refill(input bit virt, input int vmid, input int asid,
                        input int vpn, input int ppn, input bit glob);
    @(negedge clk);
    set_refill(virt, vmid, asid, vpn, ppn, glob);
    @(posedge clk); #1;
    rf_valid = 0;
  endtask

  task automatic fence(input int kind, input bit virt, input int cur,
                       input bit ua, input int asid, input bit uv, input int vpn,
                       input bit um, input int vmid);
    @(negedge clk);
    set_fence(kind, virt, cur, ua, asid, uv, vpn, um, vmid);
    @(posedge clk); #1;
    fn_valid = 0;
  endtask

  task automatic look(input bit virt, input int vmid, input int asid, input int vpn,
                      input bit exp_hit, input int exp_ppn, input string req);
    @(negedge clk);
    set_look(virt, vmid, asid, vpn);
    @(posedge clk); #1;
    lk_valid = 0;
    chk(lk_hit == exp_hit, req, $sformatf("hit vpn=%0h", vpn), lk_hit, exp_hit);
    if (exp_hit && lk_hit)
      chk(lk_ppn == PPN_W'(exp_ppn), req, $sformatf("ppn vpn=%0h", vpn), lk_ppn, exp_ppn);
  endtask

  task automatic t_reset();
    do_reset();
    chk(lk_hit == 1'b0, "R1", "hit after reset", lk_hit, 0);
    look(0, 0, 0, 0, 0, 0, "R1");
    look(1, 0, 0, 0, 0, 0, "R1");
  endtask

  task automatic t_match();
    do_reset();
    refill(0, 0, 5, 'h100, 'hA, 0);
    refill(1, 1, 5, 'h100, 'hB, 0);
    refill(1, 2, 5, 'h100, 'hC, 0);
    refill(0, 0, 9, 'h200, 'hD, 1);
    look(0, 0, 5, 'h100, 1, 'hA, "R2");
    look(1, 1, 5, 'h100, 1, 'hB, "R2");
    look(1, 2, 5, 'h100, 1, 'hC, "R2");
    look(1, 3, 5, 'h100, 0, 0, "R2");
    look(0, 0, 6, 'h100, 0, 0, "R2");
    look(0, 0, 5, 'h101, 0, 0, "R2");
    look(0, 0, 4, 'h200, 1, 'hD, "R2");
    look(1, 0, 9, 'h200, 0, 0, "R2");
  endtask

  task automatic t_fence_cycle();
    do_reset();
    refill(0, 0, 1, 'h10, 'h1, 0);
    @(negedge clk);
    set_look(0, 0, 1, 'h10);
    set_fence(2, 0, 0, 0, 0, 0, 0, 0, 0);
    @(posedge clk); #1;
    lk_valid = 0; fn_valid = 0;
    chk(lk_hit == 1'b0, "R3", "lookup during fence", lk_hit, 0);
    look(0, 0, 1, 'h10, 1, 'h1, "R3");
  endtask

  task automatic t_round_robin();
    do_reset();
    for (int i = 0; i < ENTRIES; i++) refill(0, 0, 1, 'h20 + i, 'h40 + i, 0);
    for (int i = 0; i < ENTRIES; i++) look(0, 0, 1, 'h20 + i, 1, 'h40 + i, "R4");
    refill(0, 0, 1, 'h20 + ENTRIES, 'h99, 0);
    look(0, 0, 1, 'h20, 0, 0, "R4");
    look(0, 0, 1, 'h21, 1, 'h41, "R4");
    look(0, 0, 1, 'h20 + ENTRIES, 1, 'h99, "R4");
    refill(0, 0, 1, 'h22, 'h77, 0);
    look(0, 0, 1, 'h22, 1, 'h77, "R4");
    refill(0, 0, 1, 'h50, 'h55, 0);
    look(0, 0, 1, 'h21, 0, 0, "R4");
    look(0, 0, 1, 'h22, 1, 'h77, "R4");
    look(0, 0, 1, 'h50, 1, 'h55, "R4");
  endtask

  task automatic t_refill_drop();
    do_reset();
    @(negedge clk);
    set_refill(0, 0, 1, 'h30, 'h3, 0);
    set_fence(2, 0, 0, 0, 0, 0, 0, 1, 3);
    @(posedge clk); #1;
    rf_valid = 0; fn_valid = 0;
    look(0, 0, 1, 'h30, 0, 0, "R5");
    refill(0, 0, 1, 'h30, 'h3, 0);
    look(0, 0, 1, 'h30, 1, 'h3, "R5");
  endtask

  task automatic t_sfence_host();
    do_reset();
    refill(0, 0, 1, 'h50, 'h1, 0);
    refill(0, 0, 2, 'h51, 'h2, 0);
    refill(1, 1, 1, 'h50, 'h3, 0);
    fence(0, 0, 1, 1, 1, 0, 0, 0, 0);
    look(0, 0, 1, 'h50, 0, 0, "R6");
    look(0, 0, 2, 'h51, 1, 'h2, "R6");
    look(1, 1, 1, 'h50, 1, 'h3, "R6");
    fence(0, 0, 1, 0, 0, 1, 'h51, 0, 0);
    look(0, 0, 2, 'h51, 0, 0, "R6");
    look(1, 1, 1, 'h50, 1, 'h3, "R6");
  endtask

  task automatic t_guest_fences();
    do_reset();
    refill(1, 1, 1, 'h60, 'h1, 0);
    refill(1, 1, 2, 'h61, 'h2, 0);
    refill(1, 2, 1, 'h60, 'h3, 0);
    refill(0, 0, 1, 'h60, 'h4, 0);
    fence(0, 1, 1, 1, 1, 0, 0, 0, 0);
    look(1, 1, 1, 'h60, 0, 0, "R7");
    look(1, 1, 2, 'h61, 1, 'h2, "R7");
    look(1, 2, 1, 'h60, 1, 'h3, "R7");
    look(0, 0, 1, 'h60, 1, 'h4, "R7");
    fence(1, 0, 1, 0, 0, 0, 0, 0, 0);
    look(1, 1, 2, 'h61, 0, 0, "R7");
    look(1, 2, 1, 'h60, 1, 'h3, "R7");
    look(0, 0, 1, 'h60, 1, 'h4, "R7");
  endtask

  task automatic t_gphys();
    do_reset();
    refill(1, 1, 1, 'h70, 'h1, 0);
    refill(1, 2, 1, 'h71, 'h2, 0);
    refill(0, 0, 1, 'h70, 'h3, 0);
    fence(2, 0, 0, 1, 7, 1, 'h999, 1, 1);
    look(1, 1, 1, 'h70, 0, 0, "R8");
    look(1, 2, 1, 'h71, 1, 'h2, "R8");
    look(0, 0, 1, 'h70, 1, 'h3, "R8");
    fence(2, 0, 0, 0, 0, 0, 0, 0, 0);
    look(1, 2, 1, 'h71, 0, 0, "R8");
    look(0, 0, 1, 'h70, 1, 'h3, "R8");
  endtask

  task automatic t_global();
    do_reset();
    refill(0, 0, 3, 'h80, 'h1, 1);
    refill(1, 1, 3, 'h81, 'h2, 1);
    fence(0, 0, 0, 1, 3, 0, 0, 0, 0);
    look(0, 0, 3, 'h80, 1, 'h1, "R9");
    fence(1, 0, 1, 1, 3, 0, 0, 0, 0);
    look(1, 1, 3, 'h81, 1, 'h2, "R9");
    fence(0, 0, 0, 0, 0, 1, 'h80, 0, 0);
    look(0, 0, 3, 'h80, 0, 0, "R9");
    fence(2, 0, 0, 0, 0, 0, 0, 1, 1);
    look(1, 1, 3, 'h81, 0, 0, "R9");
  endtask

  task automatic t_reserved();
    do_reset();
    refill(0, 0, 1, 'h90, 'h1, 0);
    refill(1, 1, 1, 'h90, 'h2, 0);
    fence(3, 1, 1, 0, 0, 0, 0, 0, 0);
    look(0, 0, 1, 'h90, 1, 'h1, "R10");
    look(1, 1, 1, 'h90, 1, 'h2, "R10");
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1;
    idle_inputs();
    t_reset();
    t_match();
    t_fence_cycle();
    t_round_robin();
    t_refill_drop();
    t_sfence_host();
    t_guest_fences();
    t_gphys();
    t_global();
    t_reserved();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule